// File: doc/BRIEF.md
# Hash Chaining-State Save/Restore Window

This block is the register window that software uses to suspend and resume a multi-algorithm hash engine. The engine's chaining state is reached through one data address. Each access to that address moves an internal word pointer forward. As a result, software saves or restores the whole state by reading or writing that single address again and again. The number of state words in a sequence depends on the algorithm chosen in the mode register: short-state algorithms use 8 words and long-state algorithms use 16.

Two further registers hold the 64-bit count of processed message bytes, split into a low half and a high half. A status bit reports that the engine is busy. While the engine is busy, the chain data cannot be reached, so partial results are never read or overwritten. When a run starts with a zero byte count, the engine seeds the state with its initial values. When the count is nonzero, the run continues from whatever words were restored. After a run ends, the words read out are the digest.

The compression function is out of scope. A stub stands in for it: it holds busy for a fixed number of cycles and then applies a simple word transform.

Top module: `hsw_state_window`

## Requirements
- R1: After reset, busy is 0, bus_rdata is 0, bus_rvalid is 0, and the mode, length-low, length-high and status registers all read 0.
- R2: Register offsets are: mode 0x000, chain data 0x004, status 0x058 (bit 0 = busy), length low 0x060, length high 0x064. A read presents its data on bus_rdata, with bus_rvalid high, for the one cycle after the request edge. Mode bits are: algorithm code [18:16], keyed-hash enable [22], endianness [31:26]. All other mode bits read 0.
- R3: Algorithm codes 1, 2 and 5 select 8 state words. Codes 3 and 4 select 16 state words. Codes 0, 6 and 7 are unsupported.
- R4: Each chain read or write moves the word pointer from word 0 upward. The access after the last word of the selected algorithm goes back to word 0.
- R5: A mode write made while idle returns the word pointer to word 0.
- R6: While busy, a chain read returns 0 and does not move the pointer. Writes to the chain, length and mode registers are ignored.
- R7: With an unsupported algorithm, chain reads return 0, chain writes are ignored and run_start is ignored.
- R8: A start with a 64-bit length of 0 loads word i with 0x5A5A0000 + i*0x00010001 before processing. A start with a nonzero length keeps the restored words.
- R9: An accepted start holds busy high for exactly BUSY_CYCLES cycles (default 8). At the end, each word w at index i becomes (w rotated left by 1) XOR i, and the 64-bit length grows by LEN_STEP (default 64), carrying into the high half. A start while busy is ignored.
- R10: The length registers can be written and read whatever the algorithm code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_rvalid | output | 1 | Read data valid |
| run_start | input | 1 | Pulse that starts a processing run |
| busy | output | 1 | Engine processing |

## Verification
A pointer that is off by one shows up on the very next chain read, as a word from the wrong index. A wrap at the wrong word count shows up in the read that follows the eighth or sixteenth access. If busy gating is broken, a nonzero read or a moved pointer appears within one cycle of an access during busy. If the seeding decision or the length carry is wrong, the digest words or the length halves differ from their expected values once busy falls.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
   localparam int DW     = 32;
   localparam int ALGO_W = 3;

   localparam logic [11:0] OFS_MODE   = 12'h000;
   localparam logic [11:0] OFS_CHAIN  = 12'h004;
   localparam logic [11:0] OFS_STAT   = 12'h058;
   localparam logic [11:0] OFS_LEN_LO = 12'h060;
   localparam logic [11:0] OFS_LEN_HI = 12'h064;

   localparam int ALGO_LSB = 16;
   localparam int HMAC_BIT = 22;
   localparam int END_LSB  = 26;
   localparam int END_W    = 6;

   typedef struct packed {
      logic [END_W-1:0]  endian;
      logic              hmac;
      logic [ALGO_W-1:0] algo;
   } mode_t;

   // word count of the chaining state for an algorithm code, 0 if unsupported
   function automatic logic [5:0] state_words(input logic [ALGO_W-1:0] code);
      case (code)
         3'd1, 3'd2, 3'd5: state_words = 6'd8;
         3'd3, 3'd4:       state_words = 6'd16;
         default:          state_words = 6'd0;
      endcase
   endfunction

   function automatic logic [DW-1:0] seed_word(input int idx);
      seed_word = 32'h5A5A_0000 + DW'(idx) * 32'h0001_0001;
   endfunction
endpackage

// File: rtl/hsw_word_ptr.sv
module hsw_word_ptr #(
   parameter int MAX_WORDS = 16,
   localparam int PW = $clog2(MAX_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [PW-1:0] last_idx,
   output logic [PW-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (clear)  ptr <= '0;
      else if (step)   ptr <= (ptr == last_idx) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/hsw_engine_stub.sv
module hsw_engine_stub
   import hsw_pkg::*;
#(
   parameter int MAX_WORDS   = 16,
   parameter int BUSY_CYCLES = 8,
   parameter int LEN_STEP    = 64,
   localparam int PW = $clog2(MAX_WORDS),
   localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          wr_en,
   input  logic [PW-1:0]                 wr_idx,
   input  logic [DW-1:0]                 wr_data,
   input  logic                          len_we_lo,
   input  logic                          len_we_hi,
   input  logic [DW-1:0]                 len_wdata,
   output logic [MAX_WORDS-1:0][DW-1:0]  words,
   output logic [2*DW-1:0]               len,
   output logic                          busy
);
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          accept, finish, seed;

   assign accept = start && !busy;
   assign finish = busy && (cnt_q == CW'(1));
   assign seed   = (len == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         cnt_q <= CW'(BUSY_CYCLES);
      end else if (busy) begin
         cnt_q <= cnt_q - 1'b1;
         if (finish) busy <= 1'b0;
      end
   end

   for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[g] <= '0;
         else if (accept && seed)
            words[g] <= seed_word(g);
         else if (finish)
            words[g] <= {words[g][DW-2:0], words[g][DW-1]} ^ DW'(g);
         else if (wr_en && (wr_idx == PW'(g)))
            words[g] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          len <= '0;
      else if (finish)     len <= len + (2*DW)'(LEN_STEP);
      else if (len_we_lo)  len[DW-1:0] <= len_wdata;
      else if (len_we_hi)  len[2*DW-1:DW] <= len_wdata;
   end
endmodule

// File: rtl/hsw_state_window.sv
module hsw_state_window
   import hsw_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int MAX_WORDS   = 16,
   parameter int BUSY_CYCLES = 8,
   parameter int LEN_STEP    = 64,
   localparam int PW = $clog2(MAX_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              bus_rvalid,
   input  logic              run_start,
   output logic              busy
);
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for the register offsets");
   end
   if (MAX_WORDS < 16) begin : g_bad_words
      $error("MAX_WORDS must hold the longest chaining state");
   end

   mode_t                       mode_q;
   logic [5:0]                  algo_words;
   logic                        algo_ok;
   logic [PW-1:0]               last_idx, ptr;
   logic [MAX_WORDS-1:0][DW-1:0] words;
   logic [2*DW-1:0]             len;
   logic                        rd, wr;
   logic                        hit_mode, hit_chain, hit_stat, hit_lo, hit_hi;
   logic                        chain_ok, mode_we;
   logic [DW-1:0]               rd_next;
   logic                        unused_mode_bits;

   assign unused_mode_bits = ^{bus_wdata[15:0], bus_wdata[21:19], bus_wdata[25:23]};

   assign rd = bus_sel && !bus_wr;
   assign wr = bus_sel &&  bus_wr;

   assign hit_mode  = (bus_addr == ADDR_W'(OFS_MODE));
   assign hit_chain = (bus_addr == ADDR_W'(OFS_CHAIN));
   assign hit_stat  = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_lo    = (bus_addr == ADDR_W'(OFS_LEN_LO));
   assign hit_hi    = (bus_addr == ADDR_W'(OFS_LEN_HI));

   assign algo_words = state_words(mode_q.algo);
   assign algo_ok    = (algo_words != 6'd0);
   assign last_idx   = PW'(algo_words - 6'd1);
   assign chain_ok   = bus_sel && hit_chain && !busy && algo_ok;
   assign mode_we    = wr && hit_mode && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else if (mode_we) begin
         mode_q.algo   <= bus_wdata[ALGO_LSB +: ALGO_W];
         mode_q.hmac   <= bus_wdata[HMAC_BIT];
         mode_q.endian <= bus_wdata[END_LSB +: END_W];
      end
   end

   hsw_word_ptr #(.MAX_WORDS(MAX_WORDS)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (mode_we),
      .step     (chain_ok),
      .last_idx (last_idx),
      .ptr      (ptr)
   );

   hsw_engine_stub #(
      .MAX_WORDS   (MAX_WORDS),
      .BUSY_CYCLES (BUSY_CYCLES),
      .LEN_STEP    (LEN_STEP)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (run_start && algo_ok),
      .wr_en     (chain_ok && bus_wr),
      .wr_idx    (ptr),
      .wr_data   (bus_wdata),
      .len_we_lo (wr && hit_lo && !busy),
      .len_we_hi (wr && hit_hi && !busy),
      .len_wdata (bus_wdata),
      .words     (words),
      .len       (len),
      .busy      (busy)
   );

   always_comb begin
      rd_next = '0;
      if (hit_mode) begin
         rd_next[ALGO_LSB +: ALGO_W] = mode_q.algo;
         rd_next[HMAC_BIT]           = mode_q.hmac;
         rd_next[END_LSB +: END_W]   = mode_q.endian;
      end else if (hit_chain) begin
         if (!busy && algo_ok) rd_next = words[ptr];
      end else if (hit_stat) begin
         rd_next[0] = busy;
      end else if (hit_lo) begin
         rd_next = len[DW-1:0];
      end else if (hit_hi) begin
         rd_next = len[2*DW-1:DW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd;
         bus_rdata  <= rd ? rd_next : '0;
      end
   end
endmodule

// File: rtl/hsw_state_window_chk.sv
module hsw_state_window_chk #(
   parameter int ADDR_W      = 12,
   parameter int PW          = 4,
   parameter int BUSY_CYCLES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              bus_rvalid,
   input logic              run_start,
   input logic              busy,
   input logic              algo_ok,
   input logic [PW-1:0]     ptr
);
   logic        at_chain, at_mode;
   logic [15:0] busy_run;

   assign at_chain = (bus_addr == ADDR_W'(12'h004));
   assign at_mode  = (bus_addr == ADDR_W'(12'h000));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy_run <= '0;
      else if (!busy)            busy_run <= '0;
      else if (busy_run != '1)   busy_run <= busy_run + 1'b1;
   end

   assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr) |=> bus_rvalid);

   assert_mode_clears_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && at_mode && !busy) |=> (ptr == '0));

   assert_busy_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && at_chain && busy) |=> (bus_rdata == '0));

   assert_busy_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && at_chain && busy) |=> $stable(ptr));

   assert_bad_algo_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && at_chain && !algo_ok) |=> (bus_rdata == '0));

   assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_start && !busy && algo_ok) |=> busy);

   assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < 16'(BUSY_CYCLES)));
endmodule

bind hsw_state_window hsw_state_window_chk #(
   .ADDR_W      (ADDR_W),
   .PW          (PW),
   .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .run_start  (run_start),
   .busy       (busy),
   .algo_ok    (algo_ok),
   .ptr        (ptr)
);

// File: tb/hsw_state_window_tb.sv
`timescale 1ns/1ps
module hsw_state_window_tb;
   localparam int BUSY = 8;
   localparam logic [11:0] A_MODE = 12'h000, A_CH = 12'h004, A_ST = 12'h058,
                           A_LO = 12'h060, A_HI = 12'h064;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, run_start = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid, busy;

   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   hsw_state_window #(.BUSY_CYCLES(BUSY)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .run_start(run_start), .busy(busy));

   typedef struct packed {
      logic        wr;
      logic [11:0] a;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   // R2/R3/R4/R5/R10 vectors: algo 2 (8 words)
   localparam vec_t TBL [25] = '{
      '{1'b1, 12'h000, 32'h0002_0000, 32'h0},
      '{1'b1, 12'h004, 32'hA000_0000, 32'h0},
      '{1'b1, 12'h004, 32'hA000_0001, 32'h0},
      '{1'b1, 12'h004, 32'hA000_0002, 32'h0},
      '{1'b1, 12'h004, 32'hA000_0003, 32'h0},
      '{1'b1, 12'h004, 32'hA000_0004, 32'h0},
      '{1'b1, 12'h004, 32'hA000_0005, 32'h0},
      '{1'b1, 12'h004, 32'hA000_0006, 32'h0},
      '{1'b1, 12'h004, 32'hA000_0007, 32'h0},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0000},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0001},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0002},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0003},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0004},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0005},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0006},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0007},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0000},
      '{1'b1, 12'h060, 32'h1234_5678, 32'h0},
      '{1'b1, 12'h064, 32'h0000_0009, 32'h0},
      '{1'b0, 12'h060, 32'h0, 32'h1234_5678},
      '{1'b0, 12'h064, 32'h0, 32'h0000_0009},
      '{1'b1, 12'h000, 32'hA842_0001, 32'h0},
      '{1'b0, 12'h000, 32'h0, 32'hA842_0000},
      '{1'b0, 12'h004, 32'h0, 32'hA000_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic bus_op(input logic wr, input logic [11:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output logic rv);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      rd = bus_rdata; rv = bus_rvalid;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      logic [31:0] r; logic v;
      bus_op(1'b1, a, d, r, v);
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] e);
      logic [31:0] r; logic v;
      bus_op(1'b0, a, 32'h0, r, v);
      check(req, r, e);
   endtask

   task automatic pulse_start();
      @(negedge clk); run_start = 1'b1;
      @(posedge clk); #1; run_start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 100 && busy; k++) begin
         @(posedge clk); #1;
      end
   endtask

   function automatic logic [31:0] mix(input logic [31:0] w, input int i);
      return {w[30:0], w[31]} ^ 32'(i);
   endfunction

   initial begin : watchdog
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] r; logic v; int cnt;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", 32'(busy), 32'h0);
      check("R1 rdata", bus_rdata, 32'h0);
      check("R1 rvalid", 32'(bus_rvalid), 32'h0);
      rd_chk("R1 mode", A_MODE, 32'h0);
      rd_chk("R1 len_lo", A_LO, 32'h0);
      rd_chk("R1 len_hi", A_HI, 32'h0);
      rd_chk("R1 status", A_ST, 32'h0);

      // table walk: R2 R3 R4 R5 R10
      foreach (TBL[i]) begin
         bus_op(TBL[i].wr, TBL[i].a, TBL[i].d, r, v);
         if (!TBL[i].wr) begin
            check($sformatf("R4/R2 vec %0d", i), r, TBL[i].e);
            check($sformatf("R2 rvalid vec %0d", i), 32'(v), 32'h1);
         end
      end

      // R3/R4: 16-word algorithm with wrap
      wr_reg(A_MODE, 32'h0004_0000);
      for (int i = 0; i < 16; i++) wr_reg(A_CH, 32'hB000_0000 + 32'(i));
      for (int i = 0; i < 16; i++) rd_chk("R4 16w", A_CH, 32'hB000_0000 + 32'(i));
      rd_chk("R4 wrap16", A_CH, 32'hB000_0000);

      // R8 restore, R9 carry/busy window, R6 gating
      wr_reg(A_LO, 32'hFFFF_FFF0);
      wr_reg(A_HI, 32'h0000_0003);
      pulse_start();
      check("R9 busy rise", 32'(busy), 32'h1);
      rd_chk("R6 chain read busy", A_CH, 32'h0);
      wr_reg(A_CH, 32'hDEAD_BEEF);
      wr_reg(A_LO, 32'h0);
      pulse_start();
      rd_chk("R2 status busy", A_ST, 32'h1);
      cnt = 5;
      for (int k = 0; k < 100 && busy; k++) begin
         @(posedge clk); #1; cnt++;
      end
      check("R9 busy length", 32'(cnt), 32'(BUSY));
      wr_reg(A_MODE, 32'h0004_0000);
      for (int i = 0; i < 16; i++)
         rd_chk("R8/R9 restored digest", A_CH, mix(32'hB000_0000 + 32'(i), i));
      rd_chk("R9 len_lo carry", A_LO, 32'h0000_0030);
      rd_chk("R9 len_hi carry", A_HI, 32'h0000_0004);

      // R8 seeding from zero length
      wr_reg(A_MODE, 32'h0002_0000);
      wr_reg(A_LO, 32'h0);
      wr_reg(A_HI, 32'h0);
      pulse_start();
      wait_idle();
      for (int i = 0; i < 8; i++)
         rd_chk("R8 seeded digest", A_CH, mix(32'h5A5A_0000 + 32'(i) * 32'h0001_0001, i));
      rd_chk("R9 len step", A_LO, 32'd64);

      // R7 unsupported algorithm, R10 length still accessible
      wr_reg(A_MODE, 32'h0007_0000);
      rd_chk("R7 chain zero", A_CH, 32'h0);
      wr_reg(A_CH, 32'h1234_0000);
      pulse_start();
      check("R7 start ignored", 32'(busy), 32'h0);
      wr_reg(A_LO, 32'h55);
      rd_chk("R10 len_lo bad algo", A_LO, 32'h55);
      wr_reg(A_MODE, 32'h0002_0000);
      rd_chk("R7 write ignored", A_CH, mix(32'h5A5A_0000, 0));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule